// File: doc/BRIEF.md
# Interleaved Dual-Stage Gate Timer

This block turns one fast clock into gate-enable timing for a two-stage power converter. The first stage is a boost stage and the second a forward stage. A single phase counter runs through the boost switching period. Its low bits form the oscillator ramp, and a chain of toggle flip-flops above them divides that ramp by four. The boost gate is leading-edge modulated: it rises partway through its period and falls at the period boundary. The forward gate is trailing-edge modulated: it rises at that same boundary and falls when its commanded on-time runs out. As a result, the boost turn-off and the forward turn-on share one clock edge.

Each stage has a duty word and an overcurrent flag. The duty words and the rate select are plain level inputs. Each one is captured into a holding register at its own stage's period boundary, so there is no valid/ready handshake and no back-pressure: a command that changes mid-period simply waits for the next boundary. A supervisor enable stops both gates at once and parks the counter. The rate select can run the forward stage at twice the boost switching rate.

With default parameters, the oscillator period is 16 clocks and the boost period is 64 clocks. The forward period is 64 clocks, or 32 in the double-rate variant. The boost dead time is 2 counts, the blanking window is 3 counts and the forward duty offset is 8.

Top module: `ilv_gate_timer`

## Requirements
- R1: While `rst_n` or `run_en` is low, both gates are low. After `run_en` rises, the phase count restarts at 0, so the boost gate is low for the first 2 counts of the first period.
- R2: The boost period is 64 clocks (4 oscillator periods). Within it, the boost gate is high for the last N counts, where N is the held `boost_duty` value (clamped as in R3). The gate falls at count 0 of the next period.
- R3: The boost gate is always low during counts 0 and 1 of its period (dead time). Any `boost_duty` of 62 or more gives exactly 62 high counts.
- R4: The forward gate is high from count 0 of its period for (`fwd_duty` − 8) counts, and low afterwards.
- R5: A held `fwd_duty` of 8 or less gives a forward gate that stays low for the whole period.
- R6: The forward gate is never high for more than half of its period: 32 counts at the normal rate.
- R7: With `rate_sel` = 1, the forward period is 32 clocks and its on-time is capped at 16 counts. The boost timing does not change.
- R8: When the forward on-time is nonzero, the clock cycle in which the boost gate falls at a period end is the same cycle in which the forward gate rises.
- R9: `boost_oc` high forces the boost gate low in that same cycle. The gate then stays low until the boost period ends.
- R10: `fwd_oc` high at forward count 3 or later forces the forward gate low in that cycle. The gate then stays low until the forward period ends.
- R11: `fwd_oc` during forward counts 0 to 2 (blanking) has no effect on the forward gate.
- R12: `boost_duty` and `rate_sel` are captured in the last count of the boost period, and `fwd_duty` in the last count of the forward period. While `run_en` is low, all three are captured every cycle. A change mid-period takes effect only in the next period.
- R13: Dropping `run_en` mid-period pulls both gates low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; one count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Supervisor enable; low parks the counter and blanks both gates |
| rate_sel | input | 1 | 0: both stages at a quarter of the ramp rate; 1: forward stage at half |
| boost_duty | input | 7 | Boost on-time in counts, held per boost period |
| fwd_duty | input | 7 | Forward command; on-time is this value minus 8, held per forward period |
| boost_oc | input | 1 | Boost cycle-by-cycle overcurrent flag |
| fwd_oc | input | 1 | Forward cycle-by-cycle overcurrent flag, blanked after turn-on |
| boost_gate | output | 1 | Boost stage gate enable |
| fwd_gate | output | 1 | Forward stage gate enable |

## Verification
The bench drives saturated duty words against the dead-time and half-period caps. A design without those caps would hold the boost gate high through counts 0 and 1, or stretch the forward pulse past 32 counts. It places overcurrent flags on both sides of the blanking window and mid-pulse. A wrong latch would either trip on the masked flag or release the gate before the period ends. It also changes duty words mid-period and drops the enable mid-pulse. A design without holding registers would shift the current pulse, and one without a direct gating path would leave a gate high for a cycle after disable. The double-rate variant and the shared edge between the boost fall and the forward rise are checked cycle by cycle against a model of the requirements.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Forward-stage rate variant, captured at boost period boundaries.
  typedef enum logic {
    RATE_SAME   = 1'b0,
    RATE_FWD_X2 = 1'b1
  } rate_e;

endpackage

// File: rtl/ilv_phase_ctr.sv
// Shared phase counter: an oscillator ramp counter in the low bits,
// followed by a chain of toggle flip-flops that divides the ramp.
module ilv_phase_ctr #(
  parameter int OSC_W      = 4,
  parameter int DIV_STAGES = 2,
  localparam int CW        = OSC_W + DIV_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  output logic [CW-1:0] phase_o,
  output logic          full_wrap_o,
  output logic          half_wrap_o
);

  logic [OSC_W-1:0]      osc_q;
  logic [DIV_STAGES-1:0] tff_q;
  logic [DIV_STAGES-1:0] toggle;
  logic                  osc_end;

  assign osc_end = &osc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       osc_q <= '0;
    else if (!run_en) osc_q <= '0;
    else              osc_q <= osc_q + 1'b1;
  end

  // Each divider stage toggles when the ramp and every lower stage wrap.
  for (genvar i = 0; i < DIV_STAGES; i++) begin : g_div
    if (i == 0) begin : g_first
      assign toggle[i] = osc_end;
    end else begin : g_next
      assign toggle[i] = toggle[i-1] & tff_q[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         tff_q[i] <= 1'b0;
      else if (!run_en)   tff_q[i] <= 1'b0;
      else if (toggle[i]) tff_q[i] <= ~tff_q[i];
    end
  end

  assign phase_o     = {tff_q, osc_q};
  assign full_wrap_o = &phase_o;
  assign half_wrap_o = &phase_o[CW-2:0];

endmodule

// File: rtl/ilv_lead_stage.sv
// Leading-edge modulated boost gate: rises late in the period and
// falls at the boundary, with a forced dead time at period start.
module ilv_lead_stage #(
  parameter int CW   = 6,
  parameter int DW   = 7,
  parameter int DEAD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] phase_i,
  input  logic          wrap_i,
  input  logic [DW-1:0] duty_i,
  input  logic          oc_i,
  output logic          gate_o
);

  localparam int PERIOD = 1 << CW;
  localparam int MAX_ON = PERIOD - DEAD;
  localparam logic [DW-1:0] PERIOD_W = DW'(PERIOD);
  localparam logic [DW-1:0] MAX_ON_W = DW'(MAX_ON);

  logic [DW-1:0] duty_q;
  logic          trip_q;
  logic [DW-1:0] on_len;
  logic [DW-1:0] rise_at;
  logic          in_window;

  // Command hold: reloads only at the boundary or while parked.
  always_ff @(posedge clk) begin
    if (!rst_n)                 duty_q <= '0;
    else if (!run_en || wrap_i) duty_q <= duty_i;
  end

  // Overcurrent trip: holds the gate off for the rest of the period.
  always_ff @(posedge clk) begin
    if (!rst_n)       trip_q <= 1'b0;
    else if (!run_en) trip_q <= 1'b0;
    else if (wrap_i)  trip_q <= 1'b0;
    else if (oc_i)    trip_q <= 1'b1;
  end

  always_comb begin
    on_len    = (duty_q > MAX_ON_W) ? MAX_ON_W : duty_q;
    rise_at   = PERIOD_W - on_len;
    in_window = DW'(phase_i) >= rise_at;
  end

  assign gate_o = run_en & in_window & ~trip_q & ~oc_i;

endmodule

// File: rtl/ilv_trail_stage.sv
// Trailing-edge modulated forward gate: rises at its period start,
// falls after the commanded on-time; capped at half of its period.
module ilv_trail_stage #(
  parameter int CW     = 6,
  parameter int DW     = 7,
  parameter int OFFSET = 8,
  parameter int BLANK  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] phase_i,
  input  logic          full_wrap_i,
  input  logic          half_wrap_i,
  input  logic          rate_sel_i,
  input  logic [DW-1:0] duty_i,
  input  logic          oc_i,
  output logic          gate_o,
  output logic          rate_o
);
  import ilv_pkg::*;

  localparam int PERIOD = 1 << CW;
  localparam logic [DW-1:0] LIM_SAME = DW'(PERIOD / 2);
  localparam logic [DW-1:0] LIM_X2   = DW'(PERIOD / 4);
  localparam logic [DW-1:0] OFFSET_W = DW'(OFFSET);
  localparam logic [CW-1:0] BLANK_W  = CW'(BLANK);

  rate_e         rate_q;
  logic [DW-1:0] duty_q;
  logic          trip_q;
  logic          wrap_b;
  logic [CW-1:0] ph_b;
  logic [DW-1:0] lim;
  logic [DW-1:0] excess;
  logic [DW-1:0] on_len;
  logic          in_window;
  logic          blank_done;
  logic          oc_live;

  // The rate only changes where both period variants end together.
  always_ff @(posedge clk) begin
    if (!rst_n)                      rate_q <= RATE_SAME;
    else if (!run_en || full_wrap_i) rate_q <= rate_e'(rate_sel_i);
  end

  assign wrap_b = (rate_q == RATE_FWD_X2) ? half_wrap_i : full_wrap_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                 duty_q <= '0;
    else if (!run_en || wrap_b) duty_q <= duty_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       trip_q <= 1'b0;
    else if (!run_en) trip_q <= 1'b0;
    else if (wrap_b)  trip_q <= 1'b0;
    else if (oc_live) trip_q <= 1'b1;
  end

  always_comb begin
    if (rate_q == RATE_FWD_X2) begin
      ph_b = {1'b0, phase_i[CW-2:0]};
      lim  = LIM_X2;
    end else begin
      ph_b = phase_i;
      lim  = LIM_SAME;
    end
    excess     = (duty_q > OFFSET_W) ? (duty_q - OFFSET_W) : '0;
    on_len     = (excess > lim) ? lim : excess;
    in_window  = DW'(ph_b) < on_len;
    blank_done = ph_b >= BLANK_W;
    oc_live    = oc_i & blank_done;
  end

  assign gate_o = run_en & in_window & ~trip_q & ~oc_live;
  assign rate_o = (rate_q == RATE_FWD_X2);

endmodule

// File: rtl/ilv_gate_timer.sv
module ilv_gate_timer #(
  parameter int OSC_W      = 4,
  parameter int DEAD_CNT   = 2,
  parameter int BLANK_CNT  = 3,
  parameter int FWD_OFFSET = 8,
  localparam int CW        = OSC_W + 2,
  localparam int DW        = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          rate_sel,
  input  logic [DW-1:0] boost_duty,
  input  logic [DW-1:0] fwd_duty,
  input  logic          boost_oc,
  input  logic          fwd_oc,
  output logic          boost_gate,
  output logic          fwd_gate
);

  logic [CW-1:0] phase_q;
  logic          full_wrap;
  logic          half_wrap;
  logic          fwd_rate_q;

  ilv_phase_ctr #(
    .OSC_W      (OSC_W),
    .DIV_STAGES (2)
  ) phase_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .phase_o     (phase_q),
    .full_wrap_o (full_wrap),
    .half_wrap_o (half_wrap)
  );

  ilv_lead_stage #(
    .CW   (CW),
    .DW   (DW),
    .DEAD (DEAD_CNT)
  ) boost_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .phase_i (phase_q),
    .wrap_i  (full_wrap),
    .duty_i  (boost_duty),
    .oc_i    (boost_oc),
    .gate_o  (boost_gate)
  );

  ilv_trail_stage #(
    .CW     (CW),
    .DW     (DW),
    .OFFSET (FWD_OFFSET),
    .BLANK  (BLANK_CNT)
  ) fwd_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .phase_i     (phase_q),
    .full_wrap_i (full_wrap),
    .half_wrap_i (half_wrap),
    .rate_sel_i  (rate_sel),
    .duty_i      (fwd_duty),
    .oc_i        (fwd_oc),
    .gate_o      (fwd_gate),
    .rate_o      (fwd_rate_q)
  );

endmodule

// File: rtl/ilv_gate_timer_chk.sv
module ilv_gate_timer_chk #(
  parameter int CW    = 6,
  parameter int DEAD  = 2,
  parameter int BLANK = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          boost_oc,
  input logic          fwd_oc,
  input logic          boost_gate,
  input logic          fwd_gate,
  input logic [CW-1:0] phase,
  input logic          rate_q
);

  localparam logic [CW-1:0] LAST = '1;

  logic [CW-1:0] ph_b;
  logic [CW-1:0] last_b;
  logic [CW-1:0] half_b;

  always_comb begin
    if (rate_q) begin
      ph_b   = {1'b0, phase[CW-2:0]};
      last_b = {1'b0, {(CW-1){1'b1}}};
      half_b = CW'(1 << (CW - 2));
    end else begin
      ph_b   = phase;
      last_b = LAST;
      half_b = CW'(1 << (CW - 1));
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!boost_gate && !fwd_gate));

  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (phase == '0));

  assert_lead_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && boost_gate && phase != LAST) |=> (boost_gate || boost_oc || !run_en));

  assert_dead_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase < CW'(DEAD)) |-> !boost_gate);

  assert_trail_stays_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !fwd_gate && ph_b != last_b) |=> (!fwd_gate || !run_en));

  assert_half_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_b >= half_b) |-> !fwd_gate);

  assert_shared_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $fell(boost_gate) && !boost_oc) |-> (phase == '0));

  assert_boost_oc_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boost_oc |-> !boost_gate);

  assert_boost_oc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && boost_oc && phase != LAST) |=> (!boost_gate));

  assert_fwd_oc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_oc && ph_b >= CW'(BLANK)) |-> !fwd_gate);

endmodule

bind ilv_gate_timer ilv_gate_timer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .boost_oc   (boost_oc),
  .fwd_oc     (fwd_oc),
  .boost_gate (boost_gate),
  .fwd_gate   (fwd_gate),
  .phase      (phase_q),
  .rate_q     (fwd_rate_q)
);

// File: tb/ilv_gate_timer_tb_top.sv
module ilv_gate_timer_tb_top;

  localparam int P   = 64;
  localparam int DT  = 2;
  localparam int OFF = 8;
  localparam int BLK = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       rate_sel = 1'b0;
  logic [6:0] boost_duty = '0;
  logic [6:0] fwd_duty = '0;
  logic       boost_oc = 1'b0;
  logic       fwd_oc = 1'b0;
  logic       boost_gate;
  logic       fwd_gate;

  int checks = 0;
  int errors = 0;
  bit sa [0:511];
  bit sb [0:511];

  always #5 clk = ~clk;

  ilv_gate_timer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .rate_sel   (rate_sel),
    .boost_duty (boost_duty),
    .fwd_duty   (fwd_duty),
    .boost_oc   (boost_oc),
    .fwd_oc     (fwd_oc),
    .boost_gate (boost_gate),
    .fwd_gate   (fwd_gate)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_boost(input int k, input int d);
    int p, eff;
    p   = k % P;
    eff = (d > P - DT) ? P - DT : d;
    return p >= P - eff;
  endfunction

  function automatic bit exp_fwd(input int k, input int d, input int pb);
    int cb, sub, lim, on;
    cb  = k % pb;
    sub = (d > OFF) ? d - OFF : 0;
    lim = pb / 2;
    on  = (sub > lim) ? lim : sub;
    return cb < on;
  endfunction

  // Held command for the period containing count k.
  function automatic int held(input int k, input int pl, input int d0,
                              input int d1, input int sw);
    int s;
    s = k - (k % pl);
    if (s == 0) return d0;
    return (s - 1 >= sw) ? d1 : d0;
  endfunction

  // Runs n counts from a fresh enable and compares both gates to the model.
  task automatic run_case(input string req, input int n,
                          input int da0, input int da1, input int asw,
                          input int db0, input int db1, input int bsw,
                          input int half, input int oa, input int ob);
    int pb, bad_a, bad_b, fa, fb;
    bit ea, eb, aa, ab, xa, xb;
    pb = half ? P / 2 : P;
    bad_a = 0; bad_b = 0; fa = -1; fb = -1;
    aa = 0; ab = 0; xa = 0; xb = 0;
    @(negedge clk);
    run_en = 1'b0; rate_sel = half[0];
    boost_duty = 7'(da0); fwd_duty = 7'(db0);
    boost_oc = 1'b0; fwd_oc = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      boost_oc   = (k == oa);
      fwd_oc     = (k == ob);
      boost_duty = 7'((k >= asw) ? da1 : da0);
      fwd_duty   = 7'((k >= bsw) ? db1 : db0);
      #2;
      ea = exp_boost(k, held(k, P, da0, da1, asw));
      if (oa >= 0 && k >= oa && k < oa - (oa % P) + P) ea = 1'b0;
      eb = exp_fwd(k, held(k, pb, db0, db1, bsw), pb);
      if (ob >= 0 && (ob % pb) >= BLK && k >= ob && k < ob - (ob % pb) + pb) eb = 1'b0;
      sa[k] = boost_gate;
      sb[k] = fwd_gate;
      if (boost_gate !== ea) begin
        if (bad_a == 0) begin fa = k; aa = boost_gate; xa = ea; end
        bad_a++;
      end
      if (fwd_gate !== eb) begin
        if (bad_b == 0) begin fb = k; ab = fwd_gate; xb = eb; end
        bad_b++;
      end
      @(negedge clk);
    end
    boost_oc = 1'b0; fwd_oc = 1'b0; run_en = 1'b0;
    chk(bad_a == 0, req, $sformatf("boost waveform (first mismatch count %0d)", fa),
        int'(aa), int'(xa));
    chk(bad_b == 0, req, $sformatf("fwd waveform (first mismatch count %0d)", fb),
        int'(ab), int'(xb));
  endtask

  task automatic t_reset;
    run_en = 1'b1; boost_duty = 7'd127; fwd_duty = 7'd127;
    repeat (3) @(negedge clk);
    #2;
    chk(!boost_gate && !fwd_gate, "R1", "gates during reset",
        int'({boost_gate, fwd_gate}), 0);
    @(negedge clk);
    run_en = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!boost_gate && !fwd_gate, "R1", "gates while disabled",
        int'({boost_gate, fwd_gate}), 0);
  endtask

  task automatic t_basic;
    run_case("R2 R4", 192, 20, 20, 999, 28, 28, 999, 0, -1, -1);
    chk(sa[63] && !sa[64], "R8", "boost high at 63, low at 64",
        int'({sa[63], sa[64]}), 2);
    chk(!sb[63] && sb[64], "R8", "fwd low at 63, high at 64",
        int'({sb[63], sb[64]}), 1);
    chk(!sa[43] && sa[44], "R2", "boost rises at count 44",
        int'({sa[43], sa[44]}), 1);
    chk(sb[19] && !sb[20], "R4", "fwd falls at count 20",
        int'({sb[19], sb[20]}), 2);
  endtask

  task automatic t_limits;
    run_case("R3 R6", 128, 127, 127, 999, 127, 127, 999, 0, -1, -1);
    chk(!sa[64] && !sa[65] && sa[66], "R3", "dead counts 0,1 then on",
        int'({sa[64], sa[65], sa[66]}), 1);
    chk(sb[31] && !sb[32], "R6", "fwd capped at 32 counts",
        int'({sb[31], sb[32]}), 2);
  endtask

  task automatic t_rate;
    run_case("R7", 128, 10, 10, 999, 127, 127, 999, 1, -1, -1);
    chk(sb[15] && !sb[16] && sb[32], "R7", "fwd 16 on per 32-count period",
        int'({sb[15], sb[16], sb[32]}), 5);
    chk(!sa[53] && sa[54], "R7", "boost unchanged at double rate",
        int'({sa[53], sa[54]}), 1);
  endtask

  task automatic t_offset;
    run_case("R5", 128, 0, 0, 999, 8, 8, 999, 0, -1, -1);
    chk(!sb[0] && !sb[64], "R5", "fwd at offset stays low", int'({sb[0], sb[64]}), 0);
    run_case("R5", 64, 0, 0, 999, 5, 5, 999, 0, -1, -1);
    run_case("R5", 64, 0, 0, 999, 9, 9, 999, 0, -1, -1);
    chk(sb[0] && !sb[1], "R5", "offset plus one gives one count",
        int'({sb[0], sb[1]}), 2);
  endtask

  task automatic t_boost_oc;
    run_case("R9", 128, 40, 40, 999, 0, 0, 999, 0, 30, -1);
    chk(sa[29] && !sa[30], "R9", "boost off in the trip cycle",
        int'({sa[29], sa[30]}), 2);
    chk(!sa[50] && sa[88], "R9", "boost off to period end, back next period",
        int'({sa[50], sa[88]}), 1);
  endtask

  task automatic t_fwd_oc;
    run_case("R11", 64, 0, 0, 999, 28, 28, 999, 0, -1, 1);
    chk(sb[1] && sb[2] && sb[19], "R11", "flag in blanking ignored",
        int'({sb[1], sb[2], sb[19]}), 7);
    run_case("R10", 192, 0, 0, 999, 28, 28, 999, 0, -1, 69);
    chk(sb[68] && !sb[69] && !sb[75], "R10", "fwd trips and stays off",
        int'({sb[68], sb[69], sb[75]}), 4);
    chk(sb[128], "R10", "fwd resumes next period", int'(sb[128]), 1);
  endtask

  task automatic t_hold;
    run_case("R12", 128, 20, 50, 10, 28, 12, 10, 0, -1, -1);
    chk(!sa[40] && sa[84], "R12", "boost change waits for boundary",
        int'({sa[40], sa[84]}), 1);
    chk(sb[10] && sb[67] && !sb[74], "R12", "fwd change waits for boundary",
        int'({sb[10], sb[67], sb[74]}), 6);
  endtask

  task automatic t_disable;
    @(negedge clk);
    run_en = 1'b0; rate_sel = 1'b0; boost_duty = 7'd127; fwd_duty = 7'd127;
    @(negedge clk);
    run_en = 1'b1;
    repeat (20) @(negedge clk);
    #2;
    chk(boost_gate && fwd_gate, "R13", "both high before disable",
        int'({boost_gate, fwd_gate}), 3);
    @(negedge clk);
    run_en = 1'b0;
    #2;
    chk(!boost_gate && !fwd_gate, "R13", "both low in disable cycle",
        int'({boost_gate, fwd_gate}), 0);
    @(negedge clk);
    @(negedge clk);
    run_en = 1'b1;
    #2;
    chk(!boost_gate && fwd_gate, "R1", "restart at count 0",
        int'({boost_gate, fwd_gate}), 1);
    @(negedge clk);
    #2;
    chk(!boost_gate, "R1", "count 1 still dead", int'(boost_gate), 0);
    @(negedge clk);
    #2;
    chk(boost_gate, "R1", "boost on at count 2", int'(boost_gate), 1);
    run_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_limits();
    t_rate();
    t_offset();
    t_boost_oc();
    t_fwd_oc();
    t_hold();
    t_disable();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule